// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block drives the pin that signals a watchdog expiry to the rest of the board. When the watchdog raises its trigger, the block asserts the pin for a programmable number of microseconds and then releases it. A free-running 1 MHz tick enable, supplied from outside, sets the pace of the pulse count. The pin is presented as a data value and an output-enable. The pad turns these into either a push-pull or an open-drain output.

One 32-bit configuration register sets the pulse length, the active level and the drive style. The pulse length is an ordinary field in the low bits. The two mode bits cannot be written directly. Each is changed only when the top byte of a write carries one of four key values. Any other top byte leaves both modes as they were, and the length field in the same write is still applied. Reads return the two modes as plain bits 31 and 30.

Top module: `ext_rst_pulse`

## Requirements
- R1: After reset the register reads 0x000000FF, which is active-low, open-drain and a length field of 0xFF. The pin is released, with output-enable 0 and data 0.
- R2: Every write loads the length field, bits WIDTH_BITS-1:0 (20 by default), from the written data, whatever the top byte holds. Bits 29 down to WIDTH_BITS always read 0.
- R3: Writing a top byte (bits 31:24) of 0xA5 makes the pin active-high, and bit 31 then reads 1. Writing 0x5A makes it active-low, and bit 31 then reads 0.
- R4: Writing a top byte of 0xA8 selects push-pull drive, and bit 30 then reads 1. Writing 0x8A selects open-drain drive, and bit 30 then reads 0.
- R5: A write whose top byte is any other value leaves bits 31 and 30 unchanged.
- R6: A trigger seen while no pulse is running starts a pulse in the next cycle. The pulse ends after exactly N+1 tick pulses, where N is the length field. A tick in the same cycle as the trigger is not counted.
- R7: A trigger that arrives while a pulse is running has no effect on that pulse.
- R8: In push-pull mode the output-enable is always 1. The data is the active level during a pulse and the opposite level at all other times.
- R9: In open-drain mode the data is always the active level. The output-enable is 1 only during a pulse.
- R10: The length is captured when the pulse starts. A write to the length field during a pulse takes effect from the next pulse onward.
- R11: A length field of 0 gives a pulse of exactly one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Configuration register write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Register read value |
| tick1us | input | 1 | One-cycle 1 MHz tick enable |
| fire | input | 1 | Watchdog expiry trigger |
| pinData | output | 1 | Pin data value |
| pinOe | output | 1 | Pin output-enable |

## Verification
The bench targets the key decode. It writes near-miss top bytes and all four keys, mixed with random data. A decoder that matches only part of the byte would flip a mode bit on a non-key write. A decoder that gates the length field on the key would leave a stale length. It measures pulse lengths at 0, small random values and the 0xFF default. An off-by-one counter gives N or N+2 ticks. A counter that counts the tick arriving with the trigger gives a pulse that is too short. Mid-pulse triggers and mid-pulse length writes lengthen the pulse in a design that reloads its counter. Each pulse is run in all four drive and polarity settings, so a swapped data or enable term shows up as a wrong pin level while the pulse is idle or running.

// File: rtl/ext_rst_pulse_pkg.sv
package ext_rst_pulse_pkg;
  localparam int REG_W = 32;
  localparam logic [7:0] KEY_ACT_HIGH   = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW    = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL  = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRAIN = 8'h8A;

  typedef struct packed {
    logic load;  // capture the length into the counter
    logic dec;   // count one tick down
  } cnt_strobe_t;

  typedef enum logic {PG_IDLE, PG_PULSE} pg_state_e;
endpackage

// File: rtl/ext_rst_pulse_ctrl.sv
module ext_rst_pulse_ctrl
  import ext_rst_pulse_pkg::*;
#(
  parameter int WIDTH_BITS  = 20,
  parameter int RESET_WIDTH = 'hFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_W-1:0]      regWdata,
  input  logic                  fire,
  input  logic                  tick1us,
  input  logic                  cntZero,
  output logic [WIDTH_BITS-1:0] widthCfg,
  output logic                  activeHigh,
  output logic                  pushPull,
  output logic                  pulseOn,
  output cnt_strobe_t           strobe
);
  localparam int KEY_LSB = REG_W - 8;

  logic [7:0] keyByte;
  pg_state_e  state, stateNext;

  assign keyByte = regWdata[REG_W-1:KEY_LSB];

  // Configuration register with keyed mode bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCfg   <= WIDTH_BITS'(RESET_WIDTH);
      activeHigh <= 1'b0;
      pushPull   <= 1'b0;
    end else if (regWe) begin
      widthCfg <= regWdata[WIDTH_BITS-1:0];
      case (keyByte)
        KEY_ACT_HIGH:   activeHigh <= 1'b1;
        KEY_ACT_LOW:    activeHigh <= 1'b0;
        KEY_PUSH_PULL:  pushPull   <= 1'b1;
        KEY_OPEN_DRAIN: pushPull   <= 1'b0;
        default: ;
      endcase
    end
  end

  // Pulse sequencing
  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      PG_IDLE: if (fire) begin
        strobe.load = 1'b1;
        stateNext   = PG_PULSE;
      end
      PG_PULSE: if (tick1us) begin
        if (cntZero) stateNext = PG_IDLE;
        else         strobe.dec = 1'b1;
      end
      default: stateNext = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PG_IDLE;
    else       state <= stateNext;
  end

  assign pulseOn = (state == PG_PULSE);
endmodule

// File: rtl/ext_rst_pulse_dp.sv
module ext_rst_pulse_dp
  import ext_rst_pulse_pkg::*;
#(
  parameter int WIDTH_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cnt_strobe_t           strobe,
  input  logic [WIDTH_BITS-1:0] widthCfg,
  input  logic                  activeHigh,
  input  logic                  pushPull,
  input  logic                  pulseOn,
  output logic                  cntZero,
  output logic                  pinData,
  output logic                  pinOe
);
  logic [WIDTH_BITS-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (strobe.load) cnt <= widthCfg;
    else if (strobe.dec)  cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_comb begin
    if (pushPull) begin
      pinOe   = 1'b1;
      pinData = pulseOn ? activeHigh : ~activeHigh;
    end else begin
      pinOe   = pulseOn;
      pinData = activeHigh;
    end
  end
endmodule

// File: rtl/ext_rst_pulse.sv
module ext_rst_pulse
  import ext_rst_pulse_pkg::*;
#(
  parameter int WIDTH_BITS  = 20,
  parameter int RESET_WIDTH = 'hFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        tick1us,
  input  logic        fire,
  output logic        pinData,
  output logic        pinOe
);
  localparam int PAD_BITS = REG_W - 2 - WIDTH_BITS;

  logic [WIDTH_BITS-1:0] widthCfg;
  logic                  activeHigh, pushPull, pulseOn, cntZero;
  cnt_strobe_t           strobe;

  ext_rst_pulse_ctrl #(.WIDTH_BITS(WIDTH_BITS), .RESET_WIDTH(RESET_WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .fire(fire), .tick1us(tick1us), .cntZero(cntZero),
    .widthCfg(widthCfg), .activeHigh(activeHigh), .pushPull(pushPull),
    .pulseOn(pulseOn), .strobe(strobe)
  );

  ext_rst_pulse_dp #(.WIDTH_BITS(WIDTH_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .widthCfg(widthCfg),
    .activeHigh(activeHigh), .pushPull(pushPull), .pulseOn(pulseOn),
    .cntZero(cntZero), .pinData(pinData), .pinOe(pinOe)
  );

  generate
    if (PAD_BITS > 0) begin : g_pad
      assign regRdata = {activeHigh, pushPull, {PAD_BITS{1'b0}}, widthCfg};
    end else begin : g_nopad
      assign regRdata = {activeHigh, pushPull, widthCfg};
    end
  endgenerate
endmodule

// File: rtl/ext_rst_pulse_chk.sv
module ext_rst_pulse_chk
  import ext_rst_pulse_pkg::*;
#(
  parameter int WIDTH_BITS = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [31:0] regWdata,
  input logic [31:0] regRdata,
  input logic        tick1us,
  input logic        fire,
  input logic        pinData,
  input logic        pinOe,
  input logic        pulseOn
);
  // R2
  width_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> regRdata[WIDTH_BITS-1:0] == $past(regWdata[WIDTH_BITS-1:0]));
  // R3
  key_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regWdata[31:24] == KEY_ACT_HIGH) |=> regRdata[31]);
  // R3
  key_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regWdata[31:24] == KEY_ACT_LOW) |=> !regRdata[31]);
  // R4
  key_pp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regWdata[31:24] == KEY_PUSH_PULL) |=> regRdata[30]);
  // R4
  key_od_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regWdata[31:24] == KEY_OPEN_DRAIN) |=> !regRdata[30]);
  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && (regWdata[31:24] == KEY_ACT_HIGH || regWdata[31:24] == KEY_ACT_LOW ||
                regWdata[31:24] == KEY_PUSH_PULL || regWdata[31:24] == KEY_OPEN_DRAIN))
    |=> $stable(regRdata[31:30]));
  // R6
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOn) |-> $past(fire));
  // R6, R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseOn) |-> $past(tick1us));
  // R7
  fire_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && !tick1us) |=> pulseOn);
  // R8
  pp_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[30] |-> (pinOe && pinData == (pulseOn ~^ regRdata[31])));
  // R9
  od_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[30] |-> (pinData == regRdata[31] && pinOe == pulseOn));
endmodule

bind ext_rst_pulse ext_rst_pulse_chk #(.WIDTH_BITS(WIDTH_BITS)) u_chk (.*);

// File: tb/test_ext_rst_pulse.sv
module test_ext_rst_pulse;
  localparam int W = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        tick1us = 1'b0;
  logic        fire = 1'b0;
  logic        pinData, pinOe;

  int nChecks = 0;
  int nFails  = 0;
  bit mAh = 1'b0, mPp = 1'b0;
  logic [W-1:0] mWidth = W'('hFF);

  ext_rst_pulse #(.WIDTH_BITS(W)) i_ext_rst_pulse (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .tick1us(tick1us), .fire(fire),
    .pinData(pinData), .pinOe(pinOe)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] expRead();
    return {mAh, mPp, 10'b0, mWidth};
  endfunction

  function automatic void modelWrite(logic [31:0] d);
    mWidth = d[W-1:0];
    case (d[31:24])
      8'hA5: mAh = 1'b1;
      8'h5A: mAh = 1'b0;
      8'hA8: mPp = 1'b1;
      8'h8A: mPp = 1'b0;
      default: ;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    modelWrite(d);
  endtask

  // Fire, optionally re-fire and rewrite the width mid pulse, count ticks.
  task automatic runPulse(input string req, input bit midFire, input bit midWrite);
    int ticks = 0;
    int k = 0;
    bit active;
    logic [W-1:0] expW = mWidth;
    logic [31:0] newCfg;
    @(negedge clk);
    fire = 1'b1; tick1us = 1'b1;  // tick with the trigger must not count
    @(negedge clk);
    fire = 1'b0; tick1us = 1'b0;
    active = mPp ? (pinData == mAh) : pinOe;
    check(active, "R6 start", {31'b0, active}, 32'd1);
    while (k < 2000) begin
      active = mPp ? (pinData == mAh) : pinOe;
      if (mPp) check(pinOe == 1'b1, "R8 oe", {31'b0, pinOe}, 32'd1);
      else     check(pinData == mAh, "R9 data", {31'b0, pinData}, {31'b0, mAh});
      if (!active) break;
      tick1us = (k % 3 == 2);
      if (tick1us) ticks++;
      fire  = midFire && (k == 1 || k == 4);
      if (midWrite && k == 2) begin
        newCfg = {8'h00, 24'(W'(expW + 5))};
        regWe = 1'b1; regWdata = newCfg;
      end else regWe = 1'b0;
      @(negedge clk);
      if (midWrite && k == 2) modelWrite(newCfg);
      k++;
    end
    tick1us = 1'b0; fire = 1'b0; regWe = 1'b0;
    if (mPp) check(pinData == ~mAh, "R8 idle", {31'b0, pinData}, {31'b0, ~mAh});
    else     check(pinOe == 1'b0, "R9 idle", {31'b0, pinOe}, 32'd0);
    check(ticks == int'(expW) + 1, req, ticks, int'(expW) + 1);
  endtask

  initial begin
    #(4 * 190000);
    nFails++; nChecks++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] tops [6] = '{8'hA5, 8'h5A, 8'hA8, 8'h8A, 8'hA4, 8'h8B};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(regRdata == 32'h0000_00FF, "R1 read", regRdata, 32'h0000_00FF);
    check(pinOe == 1'b0 && pinData == 1'b0, "R1 pin", {pinOe, pinData}, 32'd0);

    // R5 near-miss bytes, then R2 width with key byte
    writeReg(32'hA500_0000 ^ 32'h0100_0012);
    check(regRdata == expRead(), "R5 near miss", regRdata, expRead());
    writeReg(32'hA8FF_FFFF);
    check(regRdata == expRead(), "R2 R4 width+key", regRdata, expRead());

    // Random writes with key bytes mixed in
    for (int i = 0; i < 40; i++) begin
      d = $urandom;
      if ($urandom % 2) d[31:24] = tops[$urandom % 6];
      writeReg(d);
      check(regRdata == expRead(), "R2 R3 R4 R5 random", regRdata, expRead());
    end

    // R11 width zero, all four modes
    for (int m = 0; m < 4; m++) begin
      writeReg({(m[0] ? 8'hA5 : 8'h5A), 24'h0});
      writeReg({(m[1] ? 8'hA8 : 8'h8A), 24'h0});
      runPulse("R11 zero width", 1'b0, 1'b0);
    end
    // R6 random small widths, random modes
    for (int i = 0; i < 8; i++) begin
      writeReg({($urandom % 2 ? 8'hA5 : 8'h5A), 24'h0});
      writeReg({($urandom % 2 ? 8'hA8 : 8'h8A), 24'($urandom % 7)});
      runPulse("R6 duration", 1'b0, 1'b0);
    end
    // R7 re-trigger mid pulse
    writeReg({8'h8A, 24'd6});
    runPulse("R7 fire ignored", 1'b1, 1'b0);
    writeReg({8'hA8, 24'd3});
    runPulse("R7 fire ignored pp", 1'b1, 1'b0);
    // R10 width write mid pulse, then next pulse uses new width
    writeReg({8'h5A, 24'd4});
    runPulse("R10 captured width", 1'b0, 1'b1);
    check(regRdata[W-1:0] == W'(9), "R10 new width", regRdata, 32'd9);
    runPulse("R10 next pulse", 1'b0, 1'b0);
    // R6 default width 0xFF
    writeReg({8'h00, 24'hFF});
    runPulse("R6 default 256", 1'b0, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule